// File: doc/BRIEF.md
# Unipolar SPWM gate generator

This block drives the four switches of a single-phase full-bridge inverter with unipolar sinusoidal pulse width modulation. A two-phase divider turns the core clock into a half-rate enable, and that enable paces all of the PWM logic. On each enabled clock a triangular carrier takes one step. A pointer into a 64-entry sine table advances once per full carrier period.

The table value is an offset-binary reference, with 128 as the zero level. A mirror copy reflected about mid-scale gives the opposite-phase reference. Both references are scaled in amplitude by an unsigned fractional modulation index. Each scaled reference is compared against the carrier to produce the high-side gate of one bridge leg, and the low-side gate of that leg is its complement.

The index is taken in only at the start of each sine period, so a change cannot distort a half-formed cycle. Dead time, clock management and index format conversion sit outside this block.

Top module: `spwm_gate_gen`

## Requirements
- R1: While rst_n is low, all four gate outputs are 0. They stay 0 after reset release until the gates are first updated, which happens at the second rising clock edge after release.
- R2: The gate outputs change only on every second rising edge after reset release (edges 2, 4, 6, ...). On the edges in between, all four gates hold their values.
- R3: The carrier starts at 0 after reset and steps by one on each enabled clock. It counts up 0, 1, ..., 255, then down 254, ..., 1, and then returns to 0, giving a period of 510 enabled clocks.
- R4: Sine table entry k, for k in 0..63 with t = k mod 32, is 128 + m for k < 32 and 128 − m for k ≥ 32. Here m = (16·t·(32−t)·127) / (5·32·32 − 4·t·(32−t)) in integer division. The table pointer starts at 0, steps by one each time the carrier returns to 0, and wraps from 63 to 0.
- R5: The opposite-phase reference is 256 − s, limited to 255, where s is the current table entry.
- R6: Each reference r is scaled to 128 + floor(((r − 128)·M) / 256) using signed arithmetic, then limited to the range 0..255. M is the 8-bit index taken as M/256.
- R7: The index input is captured only on the enabled clock where the pointer is 0 and the carrier is 0 and counting up, which is the start of each sine period, including the first period after reset. Changes at any other time have no effect until the next such point.
- R8: On each update, leg A's high gate becomes 1 if the scaled direct reference is greater than or equal to the carrier value of that enabled clock, and 0 otherwise. Leg B's high gate follows the same rule using the scaled opposite-phase reference.
- R9: From the first update onward, each leg's low gate is the inverse of its high gate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| mod_idx | input | 8 | Modulation index, unsigned fraction M/256 |
| leg_a_hi | output | 1 | Leg A high-side gate |
| leg_a_lo | output | 1 | Leg A low-side gate |
| leg_b_hi | output | 1 | Leg B high-side gate |
| leg_b_lo | output | 1 | Leg B low-side gate |

## Verification
The bench builds the block with its default parameters: 8-bit samples and carrier, a 64-entry table and an 8-bit index. With these values one sine period takes 32,640 enabled clocks. A run of about 135,000 clocks therefore covers a complete period, the pointer wrap, and the capture of a new index at the start of the following period.

A short directed run with index 0 exercises the inclusive comparison at the carrier value 128. A run that starts at index 255 and applies random index changes mid-period shows that those changes are ignored until the wrap point.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

  typedef enum logic {
    CAR_UP   = 1'b0,
    CAR_DOWN = 1'b1
  } car_dir_e;

  // Rational sine approximation, evaluated at elaboration for table fill.
  function automatic int sine_code(int k, int entries, int width);
    int half, t, amp, mid, num, den, mag;
    half = entries / 2;
    t    = k % half;
    amp  = (2 ** (width - 1)) - 1;
    mid  = 2 ** (width - 1);
    num  = 16 * t * (half - t) * amp;
    den  = 5 * half * half - 4 * t * (half - t);
    mag  = num / den;
    return (k < half) ? (mid + mag) : (mid - mag);
  endfunction

endpackage

// File: rtl/spwm_rate_div.sv
module spwm_rate_div (
  input  logic clk,
  input  logic rst_n,
  output logic en
);
  typedef enum logic {PH_REST = 1'b0, PH_FIRE = 1'b1} phase_e;

  phase_e ph_q, ph_d;

  always_comb begin
    ph_d = (ph_q == PH_REST) ? PH_FIRE : PH_REST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_REST;
    else        ph_q <= ph_d;
  end

  assign en = (ph_q == PH_FIRE);

  // R2
  en_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> !en);

  // R2
  en_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> en);

endmodule

// File: rtl/spwm_sequencer.sv
module spwm_sequencer
  import spwm_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 6,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [MW-1:0] mod_idx,
  output logic [DW-1:0] car,
  output logic [AW-1:0] ptr,
  output logic [MW-1:0] m_eff
);
  localparam logic [DW-1:0] CAR_TOP  = DW'((2 ** DW) - 1);
  localparam logic [DW-1:0] CAR_ONE  = DW'(1);
  localparam logic [DW-1:0] CAR_ZERO = '0;

  logic [DW-1:0] car_q, car_d;
  car_dir_e      dir_q, dir_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [MW-1:0] m_q, m_d;
  logic          period_start;

  assign period_start = (car_q == CAR_ZERO) && (dir_q == CAR_UP) && (ptr_q == '0);

  always_comb begin
    car_d = car_q;
    dir_d = dir_q;
    ptr_d = ptr_q;
    m_d   = m_q;
    if (en) begin
      if (period_start) m_d = mod_idx;
      if (dir_q == CAR_UP) begin
        if (car_q == CAR_TOP) begin
          car_d = CAR_TOP - CAR_ONE;
          dir_d = CAR_DOWN;
        end else begin
          car_d = car_q + CAR_ONE;
        end
      end else begin
        if (car_q == CAR_ONE) begin
          car_d = CAR_ZERO;
          dir_d = CAR_UP;
          ptr_d = ptr_q + AW'(1);
        end else begin
          car_d = car_q - CAR_ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_q <= '0;
      dir_q <= CAR_UP;
      ptr_q <= '0;
      m_q   <= '0;
    end else begin
      car_q <= car_d;
      dir_q <= dir_d;
      ptr_q <= ptr_d;
      m_q   <= m_d;
    end
  end

  assign car   = car_q;
  assign ptr   = ptr_q;
  assign m_eff = period_start ? mod_idx : m_q;

  // R3
  car_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ((car_q == $past(car_q) + CAR_ONE) || (car_q == $past(car_q) - CAR_ONE)));

  // R2
  seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(car_q) && $stable(ptr_q) && $stable(m_q)));

  // R4
  ptr_at_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q != $past(ptr_q)) |-> (car_q == CAR_ZERO));

  // R7
  m_capture_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_q != $past(m_q)) |-> (($past(ptr_q) == '0) && ($past(car_q) == CAR_ZERO)));

endmodule

// File: rtl/spwm_sine_ref.sv
module spwm_sine_ref
  import spwm_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic [AW-1:0] ptr,
  output logic [DW-1:0] ref_dir,
  output logic [DW-1:0] ref_opp
);
  localparam int ENTRIES = 2 ** AW;
  localparam logic [DW:0]   FULL = (DW+1)'(2 ** DW);
  localparam logic [DW-1:0] TOP  = DW'((2 ** DW) - 1);

  logic [DW-1:0] tbl [ENTRIES];
  logic [DW:0]   mirror;

  for (genvar k = 0; k < ENTRIES; k++) begin : g_tbl
    assign tbl[k] = DW'(sine_code(k, ENTRIES, DW));
  end

  assign ref_dir = tbl[ptr];
  assign mirror  = FULL - {1'b0, ref_dir};
  assign ref_opp = mirror[DW] ? TOP : mirror[DW-1:0];

endmodule

// File: rtl/spwm_amp_scale.sv
module spwm_amp_scale #(
  parameter int DW = 8,
  parameter int MW = 8
) (
  input  logic [DW-1:0] ref_in,
  input  logic [MW-1:0] m,
  output logic [DW-1:0] y
);
  localparam int PW = DW + MW + 2;
  localparam logic [DW-1:0] MID = DW'(2 ** (DW - 1));
  localparam logic signed [PW-1:0] TOPS = PW'((2 ** DW) - 1);

  logic signed [DW:0]   dev;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] sum;

  always_comb begin
    dev  = $signed({1'b0, ref_in}) - $signed({1'b0, MID});
    prod = PW'(dev) * $signed({{(PW-MW){1'b0}}, m});
    sum  = (prod >>> MW) + $signed({{(PW-DW){1'b0}}, MID});
    if (sum < 0)         y = '0;
    else if (sum > TOPS) y = TOPS[DW-1:0];
    else                 y = sum[DW-1:0];
  end

endmodule

// File: rtl/spwm_leg.sv
module spwm_leg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] y_ref,
  input  logic [DW-1:0] car,
  output logic          g_hi,
  output logic          g_lo
);
  logic hi_q, lo_q, hi_d, lo_d, win;

  assign win = (y_ref >= car);

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (en) begin
      hi_d = win;
      lo_d = !win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign g_hi = hi_q;
  assign g_lo = lo_q;

  // R9
  leg_complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (g_hi != g_lo));

  // R2
  leg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(g_hi) && $stable(g_lo)));

endmodule

// File: rtl/spwm_gate_gen.sv
module spwm_gate_gen #(
  parameter int DW = 8,
  parameter int AW = 6,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] mod_idx,
  output logic          leg_a_hi,
  output logic          leg_a_lo,
  output logic          leg_b_hi,
  output logic          leg_b_lo
);
  localparam int LEGS = 2;
  localparam logic [DW-1:0] MID = DW'(2 ** (DW - 1));

  logic          en;
  logic [DW-1:0] car;
  logic [AW-1:0] ptr;
  logic [MW-1:0] m_eff;
  logic [DW-1:0] refs   [LEGS];
  logic [DW-1:0] scaled [LEGS];
  logic [LEGS-1:0] hi_v, lo_v;

  spwm_rate_div i_rate (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en)
  );

  spwm_sequencer #(.DW(DW), .AW(AW), .MW(MW)) i_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .mod_idx (mod_idx),
    .car     (car),
    .ptr     (ptr),
    .m_eff   (m_eff)
  );

  spwm_sine_ref #(.DW(DW), .AW(AW)) i_ref (
    .ptr     (ptr),
    .ref_dir (refs[0]),
    .ref_opp (refs[1])
  );

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    spwm_amp_scale #(.DW(DW), .MW(MW)) i_scale (
      .ref_in (refs[g]),
      .m      (m_eff),
      .y      (scaled[g])
    );
    spwm_leg #(.DW(DW)) i_leg (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .y_ref (scaled[g]),
      .car   (car),
      .g_hi  (hi_v[g]),
      .g_lo  (lo_v[g])
    );
  end

  assign leg_a_hi = hi_v[0];
  assign leg_a_lo = lo_v[0];
  assign leg_b_hi = hi_v[1];
  assign leg_b_lo = lo_v[1];

  // R6
  zero_index_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_eff == '0) |-> ((scaled[0] == MID) && (scaled[1] == MID)));

endmodule

// File: tb/test_spwm_gate_gen.sv
module test_spwm_gate_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] mi;
  logic       a_hi, a_lo, b_hi, b_lo;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  int m_car, m_idx, m_lat;
  bit m_up;
  logic [3:0] last_exp;
  bit rand_mi;

  spwm_gate_gen i_spwm_gate_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .mod_idx  (mi),
    .leg_a_hi (a_hi),
    .leg_a_lo (a_lo),
    .leg_b_hi (b_hi),
    .leg_b_lo (b_lo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ref_sine(int k);
    int t, n, d, mag;
    t = k % 32;
    n = 16 * t * (32 - t) * 127;
    d = 5 * 32 * 32 - 4 * t * (32 - t);
    mag = n / d;
    return (k < 32) ? 128 + mag : 128 - mag;
  endfunction

  function automatic int ref_scale(int s, int m);
    int q;
    q = ((s - 128) * m) >>> 8;
    q = q + 128;
    if (q < 0) q = 0;
    if (q > 255) q = 255;
    return q;
  endfunction

  task automatic check4(string tag, logic [3:0] exp);
    logic [3:0] act;
    act = {a_hi, a_lo, b_hi, b_lo};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s gates {a_hi,a_lo,b_hi,b_lo} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_car = 0; m_up = 1; m_idx = 0; m_lat = 0;
    last_exp = 4'b0000;
  endtask

  task automatic run_pairs(int n);
    for (int p = 0; p < n; p++) begin
      int s, s2, ya, yb;
      bit ah, bh;
      string tag;
      // odd edge: no update expected
      @(posedge clk);
      @(negedge clk);
      if (p == 0) check4("R1 hold until first update", last_exp);
      else        check4("R2 hold on off edge", last_exp);
      if (rand_mi && ($urandom_range(0, 299) == 0)) mi = 8'($urandom);
      // even edge: update
      @(posedge clk);
      @(negedge clk);
      if (m_car == 0 && m_up && m_idx == 0) m_lat = int'(mi);
      s  = ref_sine(m_idx);
      s2 = (256 - s > 255) ? 255 : 256 - s;
      ya = ref_scale(s, m_lat);
      yb = ref_scale(s2, m_lat);
      ah = (ya >= m_car);
      bh = (yb >= m_car);
      last_exp = {ah, !ah, bh, !bh};
      tag = (int'(mi) != m_lat) ? "R7 R8 R9 R3 R4 R5 R6 latched index"
                                : "R8 R9 R3 R4 R5 R6";
      check4(tag, last_exp);
      if (m_up) begin
        if (m_car == 255) begin m_car = 254; m_up = 0; end
        else m_car++;
      end else begin
        if (m_car == 1) begin m_car = 0; m_up = 1; m_idx = (m_idx + 1) % 64; end
        else m_car--;
      end
    end
  endtask

  task automatic do_reset(logic [7:0] mval);
    @(negedge clk);
    rst_n = 1'b0;
    mi = mval;
    model_reset();
    repeat (3) @(negedge clk);
    check4("R1 in reset", 4'b0000);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog expired actual %0d cycles expected at most %0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0;
    mi = 8'd0;
    rand_mi = 0;
    model_reset();
    @(negedge clk);
    check4("R1 at start of reset", 4'b0000);

    // directed: index 0, inclusive compare at carrier 128
    do_reset(8'd0);
    run_pairs(1200);

    // full index, random mid-period changes, wrap and recapture
    do_reset(8'd255);
    rand_mi = 1;
    run_pairs(64 * 510 + 64 * 510 + 100);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule